// File: doc/BRIEF.md
# Device Reset Sequencer

The reset sequencer produces the single internal register reset for a multi-channel line framer. It has two sources. The first is an active-low, level-sensitive reset pin. The second is a software reset control bit that clears itself. A reset from either source holds the internal register reset for a counted minimum number of clock cycles. Once the internal reset is released, all channels stay disabled until software enables them again.

The block also decides how the device output pins behave during each kind of reset:

- **Hardware reset:** the system-side outputs are released to high impedance.
- **Software reset:** the system-side outputs stay driven and follow the default register values.
- **Both kinds of reset:** the transmit data line outputs are forced low. The transmit clock output keeps following the transmit clock input, and the oscillator-control output stays driven.

The pin reset takes effect at once, without waiting for a clock edge. Its release is passed through a synchroniser before it reaches the cycle counter. Software starts a reset by writing one to the control bit. It then polls the bit, which falls one cycle after the internal reset has been released.

Top module: `rst_sequencer`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n` is 0, `sw_rst_bit` is 0 and `chan_en` is all zero. This takes effect without waiting for a clock edge.
- R2: After `ext_rst_n` rises, `core_rst_n` stays 0 until 34 rising clock edges have passed (SYNC_STAGES=2 plus RST_CYC=32) and is 1 after the 34th.
- R3: `sys_oe` is 0 while the pin is low and during the hold that follows its release. `vco_oe` is 1 at all times.
- R4: While `core_rst_n` is 0, `tx_pos_out` and `tx_neg_out` are 0. Otherwise they equal `tx_pos_in` and `tx_neg_in`. `tx_clk_out` always equals `tx_clk_in`.
- R5: When idle, a write strobe `sw_rst_wr` with `sw_rst_wdata`=1 sets `sw_rst_bit` and drives `core_rst_n` to 0 from the next edge, for exactly RST_CYC (32) cycles.
- R6: `sw_rst_bit` returns to 0 one clock edge after `core_rst_n` returns to 1.
- R7: `sys_oe` stays 1 throughout a software reset.
- R8: After either reset, `chan_en` is all zero. A `chan_wr` write is ignored while `core_rst_n` is 0 and takes effect on the next edge when `core_rst_n` is 1.
- R9: A write of 1 to the software reset bit is ignored, and does not restart the hold count, in three situations:
  - during a hardware reset or its hold;
  - during a software reset;
  - in the cycle between the release of `core_rst_n` and the clearing of `sw_rst_bit`.
- R10: Writing 0 to the software reset bit while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | Reset pin, active low, level-sensitive |
| sw_rst_wr | input | 1 | Write strobe for the software reset bit |
| sw_rst_wdata | input | 1 | Value written to the software reset bit |
| chan_wr | input | 1 | Write strobe for the channel enable register |
| chan_wdata | input | NCH | Channel enable write data |
| tx_clk_in | input | 1 | Transmit clock input |
| tx_pos_in | input | 1 | Positive-rail transmit data from the datapath |
| tx_neg_in | input | 1 | Negative-rail transmit data from the datapath |
| core_rst_n | output | 1 | Internal register reset, active low |
| sw_rst_bit | output | 1 | Read-back of the software reset bit |
| chan_en | output | NCH | Channel enables, one bit per channel |
| sys_oe | output | 1 | Output enable for the system-side pins |
| vco_oe | output | 1 | Output enable for the oscillator-control pin |
| tx_clk_out | output | 1 | Transmit clock output |
| tx_pos_out | output | 1 | Positive-rail transmit line output |
| tx_neg_out | output | 1 | Negative-rail transmit line output |

## Verification
The bench counts edges after release of each reset source. An off-by-one hold or a missing synchroniser stage would show up as `core_rst_n` rising one edge early or late.

It writes to the software reset bit in three places:
- in the middle of a hardware hold;
- in the middle of a software reset;
- in the single cycle after release, while the bit still reads 1.

A design that restarted its counter would lengthen the reset. A design that re-armed would leave the bit stuck.

Channel writes made during a reset must not survive the reset. The bench also checks that `sys_oe` separates the two reset kinds; a design that gated it with `core_rst_n` alone would tri-state the system side during a software reset.

// File: rtl/rstc_pkg.sv
// Package rstc_pkg
// Shared types for the reset sequencer: the cause of the reset in progress.
// Assumes nothing beyond IEEE 1800-2017.
package rstc_pkg;
    typedef enum logic [1:0] {
        RC_IDLE = 2'd0,
        RC_HW   = 2'd1,
        RC_SW   = 2'd2
    } rst_cause_e;
endpackage

// File: rtl/rstc_pin_sync.sv
// Module rstc_pin_sync
// Synchronises release of the active-low reset pin. Assertion clears the
// chain without waiting for a clock edge. Release ripples through STAGES
// flops. Assumes ext_rst_n is free of glitches shorter than a clock period.
module rstc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic ext_rst_n,
    output logic hw_done
);
    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear at once on assertion.
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) chain_q <= '0;
        else            chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign hw_done = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_hold_timer.sv
// Module rstc_hold_timer
// Counts the reset hold and owns the self-clearing software reset bit.
// Hardware reset keeps the counter loaded; once released, it counts down
// RST_CYC cycles. A software start loads the same count. The bit clears one
// edge after the count reaches zero. Assumes sw_rst_wr is a single-cycle strobe.
module rstc_hold_timer
    import rstc_pkg::*;
#(
    parameter int RST_CYC = 32
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       hw_done,
    input  logic       sw_rst_wr,
    input  logic       sw_rst_wdata,
    output logic       core_rst_n,
    output logic       sw_bit,
    output rst_cause_e cause
);
    localparam int CW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYC);

    logic [CW-1:0] cnt_q;
    logic          sw_q;
    logic          busy;
    logic          sw_start;

    assign busy     = !hw_done || (cnt_q != '0);
    assign sw_start = sw_rst_wr && sw_rst_wdata && !busy && !sw_q;

    // Hold counter: loaded by either reset source, then counts down to zero.
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)        cnt_q <= LOAD;
        else if (!hw_done)     cnt_q <= LOAD;
        else if (sw_start)     cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Software reset bit: set on an accepted write, cleared after the hold ends.
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)                 sw_q <= 1'b0;
        else if (!hw_done)              sw_q <= 1'b0;
        else if (sw_start)              sw_q <= 1'b1;
        else if (sw_q && cnt_q == '0)   sw_q <= 1'b0;
    end

    // Cause of the reset in progress, for the pin controls.
    always_comb begin
        if (!hw_done || (cnt_q != '0 && !sw_q)) cause = RC_HW;
        else if (sw_q)                          cause = RC_SW;
        else                                    cause = RC_IDLE;
    end

    assign core_rst_n = hw_done && (cnt_q == '0);
    assign sw_bit     = sw_q;

    // R2
    hw_load_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(hw_done) |-> (cnt_q == LOAD));
    // R5
    sw_start_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        sw_start |=> (sw_q && cnt_q == LOAD));
    // R6
    sw_clear_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (hw_done && $fell(sw_q)) |-> ($past(cnt_q) == '0));
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (hw_done && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rstc_pin_ctrl.sv
// Module rstc_pin_ctrl
// Output-pin controls and the channel enable register. The system side is
// tri-stated only for a hardware reset. The transmit data rails are forced
// low in any reset, while the transmit clock passes through. Channels are
// cleared while the core is in reset, and writes then are dropped.
// Assumes core_rst_n comes from flops in the clk domain.
module rstc_pin_ctrl
    import rstc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           ext_rst_n,
    input  logic           core_rst_n,
    input  rst_cause_e     cause,
    input  logic           chan_wr,
    input  logic [NCH-1:0] chan_wdata,
    input  logic           tx_clk_in,
    input  logic           tx_pos_in,
    input  logic           tx_neg_in,
    output logic [NCH-1:0] chan_en,
    output logic           sys_oe,
    output logic           vco_oe,
    output logic           tx_clk_out,
    output logic           tx_pos_out,
    output logic           tx_neg_out
);
    logic [NCH-1:0] chan_q;

    // Channel enables: cleared by any reset, written only when out of reset.
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)      chan_q <= '0;
        else if (!core_rst_n) chan_q <= '0;
        else if (chan_wr)    chan_q <= chan_wdata;
    end

    // Pin controls, decoded from the reset cause and the core reset.
    always_comb begin
        sys_oe     = (cause != RC_HW);
        vco_oe     = 1'b1;
        tx_clk_out = tx_clk_in;
        tx_pos_out = tx_pos_in && core_rst_n;
        tx_neg_out = tx_neg_in && core_rst_n;
    end

    assign chan_en = chan_q;

    // R8
    chan_clear_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!core_rst_n) |=> (chan_q == '0));
endmodule

// File: rtl/rst_sequencer.sv
// Module rst_sequencer
// Top of the device reset sequencer. Joins the pin synchroniser, the hold
// timer with the software reset bit, and the output-pin controls.
// Assumes a single clock domain; the reset pin is asynchronous to it.
module rst_sequencer
    import rstc_pkg::*;
#(
    parameter int RST_CYC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int NCH         = 4
) (
    input  logic           clk,
    input  logic           ext_rst_n,
    input  logic           sw_rst_wr,
    input  logic           sw_rst_wdata,
    input  logic           chan_wr,
    input  logic [NCH-1:0] chan_wdata,
    input  logic           tx_clk_in,
    input  logic           tx_pos_in,
    input  logic           tx_neg_in,
    output logic           core_rst_n,
    output logic           sw_rst_bit,
    output logic [NCH-1:0] chan_en,
    output logic           sys_oe,
    output logic           vco_oe,
    output logic           tx_clk_out,
    output logic           tx_pos_out,
    output logic           tx_neg_out
);
    logic       hw_done;
    rst_cause_e cause;

    rstc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .hw_done   (hw_done)
    );

    rstc_hold_timer #(.RST_CYC(RST_CYC)) i_timer (
        .clk          (clk),
        .ext_rst_n    (ext_rst_n),
        .hw_done      (hw_done),
        .sw_rst_wr    (sw_rst_wr),
        .sw_rst_wdata (sw_rst_wdata),
        .core_rst_n   (core_rst_n),
        .sw_bit       (sw_rst_bit),
        .cause        (cause)
    );

    rstc_pin_ctrl #(.NCH(NCH)) i_pins (
        .clk        (clk),
        .ext_rst_n  (ext_rst_n),
        .core_rst_n (core_rst_n),
        .cause      (cause),
        .chan_wr    (chan_wr),
        .chan_wdata (chan_wdata),
        .tx_clk_in  (tx_clk_in),
        .tx_pos_in  (tx_pos_in),
        .tx_neg_in  (tx_neg_in),
        .chan_en    (chan_en),
        .sys_oe     (sys_oe),
        .vco_oe     (vco_oe),
        .tx_clk_out (tx_clk_out),
        .tx_pos_out (tx_pos_out),
        .tx_neg_out (tx_neg_out)
    );

    // R3
    hw_tristate_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!core_rst_n && !sw_rst_bit) |-> !sys_oe);
    // R7
    sw_driven_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        sw_rst_bit |-> sys_oe);
endmodule

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           ext_rst_n = 1'b0;
    logic           sw_rst_wr = 1'b0, sw_rst_wdata = 1'b0;
    logic           chan_wr = 1'b0;
    logic [NCH-1:0] chan_wdata = '0;
    logic           tx_clk_in = 1'b0, tx_pos_in = 1'b0, tx_neg_in = 1'b0;
    logic           core_rst_n, sw_rst_bit, sys_oe, vco_oe;
    logic           tx_clk_out, tx_pos_out, tx_neg_out;
    logic [NCH-1:0] chan_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rst_sequencer i_rst_sequencer (
        .clk(clk), .ext_rst_n(ext_rst_n), .sw_rst_wr(sw_rst_wr),
        .sw_rst_wdata(sw_rst_wdata), .chan_wr(chan_wr), .chan_wdata(chan_wdata),
        .tx_clk_in(tx_clk_in), .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
        .core_rst_n(core_rst_n), .sw_rst_bit(sw_rst_bit), .chan_en(chan_en),
        .sys_oe(sys_oe), .vco_oe(vco_oe), .tx_clk_out(tx_clk_out),
        .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Vector: {pos, neg, clk, chan[3:0]} driven while idle; outputs must follow.
    localparam logic [6:0] VEC [8] = '{
        7'b1_0_1_0101, 7'b0_1_0_1010, 7'b1_1_1_1111, 7'b0_0_0_0000,
        7'b1_0_0_0001, 7'b0_1_1_1000, 7'b1_1_0_0110, 7'b0_0_1_1001
    };

    initial begin
        // R1 R3 R4 R8: reset state with the pin low.
        tx_pos_in = 1'b1; tx_neg_in = 1'b1; tx_clk_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "core_rst_n in pin reset", int'(core_rst_n), 0);
        chk("R1", "sw bit in pin reset", int'(sw_rst_bit), 0);
        chk("R8", "chan_en in pin reset", int'(chan_en), 0);
        chk("R3", "sys_oe in pin reset", int'(sys_oe), 0);
        chk("R3", "vco_oe in pin reset", int'(vco_oe), 1);
        chk("R4", "tx_pos forced", int'(tx_pos_out), 0);
        chk("R4", "tx_neg forced", int'(tx_neg_out), 0);
        chk("R4", "tx_clk follows", int'(tx_clk_out), 1);

        // R2 R9: release the pin; a software write during the hold is ignored.
        ext_rst_n = 1'b1;
        for (int k = 1; k <= 34; k++) begin
            if (k == 10) begin sw_rst_wr = 1'b1; sw_rst_wdata = 1'b1; chan_wr = 1'b1; chan_wdata = 4'hF; end
            @(negedge clk);
            sw_rst_wr = 1'b0; chan_wr = 1'b0;
            if (k == 33) begin
                chk("R2", "core_rst_n one edge before end", int'(core_rst_n), 0);
                chk("R3", "sys_oe during hold", int'(sys_oe), 0);
            end
            if (k == 34) begin
                chk("R2", "core_rst_n after hold", int'(core_rst_n), 1);
                chk("R3", "sys_oe after hold", int'(sys_oe), 1);
                chk("R9", "sw bit after write in hw hold", int'(sw_rst_bit), 0);
                chk("R8", "chan write in reset dropped", int'(chan_en), 0);
            end
        end

        // R4 R8: vector table while idle.
        foreach (VEC[i]) begin
            tx_pos_in = VEC[i][6]; tx_neg_in = VEC[i][5]; tx_clk_in = VEC[i][4];
            chan_wr = 1'b1; chan_wdata = VEC[i][3:0];
            @(negedge clk);
            chan_wr = 1'b0;
            chk("R4", "tx_pos follows", int'(tx_pos_out), int'(VEC[i][6]));
            chk("R4", "tx_neg follows", int'(tx_neg_out), int'(VEC[i][5]));
            chk("R4", "tx_clk follows", int'(tx_clk_out), int'(VEC[i][4]));
            chk("R8", "chan write idle", int'(chan_en), int'(VEC[i][3:0]));
        end

        // R10: writing zero does nothing.
        sw_rst_wr = 1'b1; sw_rst_wdata = 1'b0;
        @(negedge clk); sw_rst_wr = 1'b0;
        @(negedge clk);
        chk("R10", "sw bit after zero write", int'(sw_rst_bit), 0);
        chk("R10", "core_rst_n after zero write", int'(core_rst_n), 1);

        // R5 R6 R7 R9: software reset with writes mid-reset and in the clear window.
        chan_wr = 1'b1; chan_wdata = 4'h5; @(negedge clk); chan_wr = 1'b0;
        tx_pos_in = 1'b1; tx_neg_in = 1'b1;
        sw_rst_wr = 1'b1; sw_rst_wdata = 1'b1;
        @(negedge clk);                         // j = 0, after the start edge
        sw_rst_wr = 1'b0;
        for (int j = 0; j <= 33; j++) begin
            if (j == 0) begin
                chk("R5", "sw bit set", int'(sw_rst_bit), 1);
                chk("R5", "core_rst_n low", int'(core_rst_n), 0);
                chk("R7", "sys_oe during sw reset", int'(sys_oe), 1);
                chk("R4", "tx_pos forced in sw reset", int'(tx_pos_out), 0);
            end
            if (j == 31) chk("R5", "core_rst_n last held cycle", int'(core_rst_n), 0);
            if (j == 32) begin
                chk("R5", "core_rst_n released after 32", int'(core_rst_n), 1);
                chk("R6", "sw bit still set on release", int'(sw_rst_bit), 1);
                chk("R8", "chan cleared by sw reset", int'(chan_en), 0);
            end
            if (j == 33) begin
                chk("R6", "sw bit cleared", int'(sw_rst_bit), 0);
                chk("R9", "clear-window write ignored", int'(core_rst_n), 1);
            end
            if (j == 10 || j == 32) begin sw_rst_wr = 1'b1; sw_rst_wdata = 1'b1; end
            if (j == 12) begin chan_wr = 1'b1; chan_wdata = 4'hA; end
            if (j < 33) @(negedge clk);
            sw_rst_wr = 1'b0; chan_wr = 1'b0;
        end
        chk("R8", "chan write in sw reset dropped", int'(chan_en), 0);

        // R1: pin assertion acts without a clock edge.
        chan_wr = 1'b1; chan_wdata = 4'h3; @(negedge clk); chan_wr = 1'b0;
        #1 ext_rst_n = 1'b0;
        #0.5;
        chk("R1", "async core reset", int'(core_rst_n), 0);
        chk("R1", "async chan clear", int'(chan_en), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule